// File: doc/BRIEF.md
# Parallel I/O Port with Edge-Detect Pulse

This block is an 8-bit general purpose parallel port. Each pin is set as an input or an output by its own bit in a direction register. An output data register supplies the level on every pin that is set as an output. The block gives the pad ring an output-enable vector and an output value vector. It takes back the raw pin levels, which first pass through a two-flop synchronizer.

Software chooses which input pins are watched. For each watched pin it also chooses whether a rising or a falling edge counts. When a watched input shows its chosen edge, the block raises one shared interrupt line as a positive pulse two system clocks wide. If another edge arrives while the pulse is high, the pulse is stretched so that it stays high for two cycles after the latest edge. The port has no latched status flag; the pulse goes straight to an external interrupt controller.

The four configuration registers are written through a simple select-and-strobe port. A separate data view always shows the synchronized level for input pins and the driven value for output pins.

Top module: `gpio_edge_port`

## Requirements
- R1: A write with `wr_sel_i`=0 loads the direction register, where bit 1 means output. From the next cycle `pin_oe_o` equals the written value.
- R2: A write with `wr_sel_i`=1 loads the output data register. From the next cycle `pin_o` equals the written value.
- R3: `read_data_o` bit k shows the output data bit for output pins. For input pins it shows the pin level, sampled through two flops: a pin change that is sampled at clock edge N appears after edge N+1.
- R4: An edge on a pin that is not selected in the monitor register (`wr_sel_i`=2, bit 1 means watched), or on a pin set as an output, never raises `irq_o`.
- R5: The edge select register (`wr_sel_i`=3) picks the edge for each watched input: bit 1 means rising and bit 0 means falling. The opposite edge is ignored.
- R6: A detected edge on a pin change sampled at clock edge N makes `irq_o` high after edges N+2 and N+3, and low again after N+4. The pulse is exactly two cycles wide.
- R7: Edges detected on several pins in the same cycle give a single two-cycle pulse.
- R8: An edge detected while the pulse is high keeps `irq_o` high for two cycles after that latest edge.
- R9: After reset all pins are inputs, no pin is watched, every edge select is falling, the output data is zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 direction, 1 output data, 2 monitor, 3 edge select |
| wr_data_i | input | 8 | Register write data |
| pin_i | input | 8 | Raw pin levels from the pads |
| pin_o | output | 8 | Output data register driven to the pads |
| pin_oe_o | output | 8 | Per-pin output enable |
| read_data_o | output | 8 | Data view: synchronized inputs, driven outputs |
| irq_o | output | 1 | Shared edge interrupt pulse |

## Verification
The assertions assume that a register write and a pin change are never in the same cycle. They also assume the pin levels stay stable from one clock edge to the next, so that the synchronizer output always comes from a settled sample. The stimulus changes pins and registers only on the falling clock edge, one action at a time. Between configuring a pin and probing it, the bench waits for the synchronizer and any leftover pulse to settle, so each probe begins with `irq_o` low.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   typedef enum logic [1:0] {
      SEL_DIR  = 2'd0,
      SEL_OUT  = 2'd1,
      SEL_MON  = 2'd2,
      SEL_EDGE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   input  logic [WIDTH-1:0] watch_i,
   input  logic [WIDTH-1:0] is_out_i,
   input  logic [WIDTH-1:0] rise_i,
   output logic             any_o
);
   logic [WIDTH-1:0] hit;

   generate
      for (genvar k = 0; k < WIDTH; k++) begin : g_pin
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl_i[k];

         logic up, down;
         assign up     = lvl_i[k] & ~prev_q;
         assign down   = ~lvl_i[k] & prev_q;
         assign hit[k] = watch_i[k] & ~is_out_i[k] & (rise_i[k] ? up : down);
      end
   endgenerate

   assign any_o = |hit;
endmodule

// File: rtl/gpio_pulse_gen.sv
module gpio_pulse_gen #(
   parameter int PULSE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic pulse_o
);
   localparam int CW = $clog2(PULSE_CYC + 1);

   generate
      if (PULSE_CYC < 1) begin : g_bad
         $error("gpio_pulse_gen needs a pulse of at least one cycle");
      end
   endgenerate

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             left_q <= '0;
      else if (trig_i)        left_q <= CW'(PULSE_CYC);
      else if (left_q != '0)  left_q <= left_q - 1'b1;

   assign pulse_o = (left_q != '0);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_CYC   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] pin_o,
   output logic [WIDTH-1:0] pin_oe_o,
   output logic [WIDTH-1:0] read_data_o,
   output logic             irq_o
);
   import gpio_edge_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad
         $error("gpio_edge_port needs at least one pin");
      end
   endgenerate

   logic [WIDTH-1:0] dir_q, out_q, mon_q, rise_q;
   logic [WIDTH-1:0] lvl;
   logic             edge_any;
   reg_sel_e         sel;

   assign sel = reg_sel_e'(wr_sel_i);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         mon_q  <= '0;
         rise_q <= '0;
      end else if (wr_en_i) begin
         case (sel)
            SEL_DIR:  dir_q  <= wr_data_i;
            SEL_OUT:  out_q  <= wr_data_i;
            SEL_MON:  mon_q  <= wr_data_i;
            SEL_EDGE: rise_q <= wr_data_i;
            default:  ;
         endcase
      end

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(lvl)
   );

   gpio_edge_det #(.WIDTH(WIDTH)) u_det (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .watch_i(mon_q),
      .is_out_i(dir_q), .rise_i(rise_q), .any_o(edge_any)
   );

   gpio_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig_i(edge_any), .pulse_o(irq_o)
   );

   assign pin_o       = out_q;
   assign pin_oe_o    = dir_q;
   assign read_data_o = (dir_q & out_q) | (~dir_q & lvl);
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en_i,
   input logic [1:0]       wr_sel_i,
   input logic [WIDTH-1:0] wr_data_i,
   input logic [WIDTH-1:0] pin_o,
   input logic [WIDTH-1:0] pin_oe_o,
   input logic             irq_o,
   input logic             edge_any
);
   assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == 2'd0) |=> (pin_oe_o == $past(wr_data_i)));

   assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == 2'd1) |=> (pin_o == $past(wr_data_i)));

   assert_pulse_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_any |=> irq_o ##1 irq_o);

   assert_pulse_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> (!$past(edge_any) && !$past(edge_any, 2)));

   always @(negedge clk)
      if (!rst_n)
         assert_reset_state_R9: assert (irq_o == 1'b0 && pin_oe_o == '0 && pin_o == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
   .wr_data_i(wr_data_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
   .irq_o(irq_o), .edge_any(edge_any)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_sel_i = 2'd0;
   logic [7:0] wr_data_i = 8'h00;
   logic [7:0] pin_i = 8'h00;
   logic [7:0] pin_o, pin_oe_o, read_data_o;
   logic       irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_edge_port uut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .pin_i(pin_i), .pin_o(pin_o),
      .pin_oe_o(pin_oe_o), .read_data_o(read_data_o), .irq_o(irq_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // change pins at a falling edge, record irq over the next n falling edges
   task automatic probe(input logic [7:0] v, input int n, output logic [7:0] pat);
      @(negedge clk);
      pin_i = v;
      pat = '0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pat[i] = irq_o;
      end
   endtask

   initial begin
      logic [7:0] pat;
      logic [7:0] base;
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 oe", pin_oe_o, 0);
      check("R9 out", pin_o, 0);
      check("R9 irq", irq_o, 0);
      check("R9 read", read_data_o, 0);
      rst_n = 1'b1;
      idle(2);
      // R9: nothing watched after reset, so an edge gives no pulse
      probe(8'hFF, 5, pat);
      check("R9 no watch", pat, 0);
      probe(8'h00, 5, pat);
      check("R9 no watch fall", pat, 0);

      // R1, R2, R3 data view
      wr(2'd0, 8'h0F);
      check("R1 oe", pin_oe_o, 8'h0F);
      wr(2'd1, 8'hA5);
      check("R2 out", pin_o, 8'hA5);
      @(negedge clk); pin_i = 8'h3C;
      idle(3);
      check("R3 mixed read", read_data_o, 8'h35);
      // R3 latency
      @(negedge clk); pin_i = 8'hC0;
      @(negedge clk);
      check("R3 latency old", read_data_o, 8'h35);
      @(negedge clk);
      check("R3 latency new", read_data_o, 8'hC5);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      @(negedge clk); pin_i = 8'h00;
      idle(4);

      // R4 R5 R6 sweep: pin, dir, monitor, edge select, transition
      for (int p = 0; p < 8; p++)
         for (int d = 0; d < 2; d++)
            for (int m = 0; m < 2; m++)
               for (int s = 0; s < 2; s++)
                  for (int up = 0; up < 2; up++) begin
                     logic exp;
                     string tag;
                     base = (up != 0) ? 8'h00 : (8'h01 << p);
                     wr(2'd2, 8'h00);
                     @(negedge clk); pin_i = base;
                     idle(4);
                     wr(2'd0, 8'(d) << p);
                     wr(2'd3, 8'(s) << p);
                     wr(2'd2, 8'(m) << p);
                     idle(1);
                     probe(base ^ (8'h01 << p), 5, pat);
                     exp = (m == 1) && (d == 0) && (s == up);
                     if (m == 0 || d == 1) tag = "R4 ignored";
                     else if (!exp)        tag = "R5 opposite";
                     else                  tag = "R6 pulse";
                     check($sformatf("%s pin=%0d dir=%0d mon=%0d rise=%0d up=%0d",
                                     tag, p, d, m, s, up),
                           pat, exp ? 8'b0000_1100 : 8'h00);
                  end

      // R7 simultaneous edges
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h00);
      @(negedge clk); pin_i = 8'h00;
      idle(4);
      wr(2'd3, 8'hFF);
      wr(2'd2, 8'hFF);
      probe(8'hFF, 6, pat);
      check("R7 shared pulse", pat, 8'b0000_1100);

      // R8 retrigger one cycle later
      wr(2'd2, 8'h00);
      @(negedge clk); pin_i = 8'h00;
      idle(4);
      wr(2'd2, 8'h03);
      @(negedge clk); pin_i = 8'h01;
      pat = '0;
      @(negedge clk); pin_i = 8'h03; pat[0] = irq_o;
      for (int i = 1; i < 7; i++) begin
         @(negedge clk);
         pat[i] = irq_o;
      end
      check("R8 extend", pat, 8'b0001_1100);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule